// File: doc/BRIEF.md
# Retirement Trace Capture Unit

This unit sits beside one core's retirement stage and builds a single merged log of what that core retired. Retiring loads contribute the value they returned, which is the thread's input and all that is needed to re-run the thread by itself later. Retiring stores and branches contribute the data that a later re-run is compared against. Every logged event becomes one tagged entry. Entries pass through a small on-chip FIFO, and the FIFO drains one entry at a time into a trace region in memory. No ordering information between cores is kept.

The region is set by an inclusive base and limit word address. Writes walk upward from the base and wrap from the limit back to the base. Before each write the unit checks the write address against the region. An address outside it causes no write: the entry is discarded, a sticky error flag is raised, and the write address reloads from the base. When the FIFO is full the unit asserts a stall back to retirement, so no event is lost. Every `cfg_window` logged entries, one entry carries a window-start mark, which lets a replay cut the log into short windows.

Top module: `trace_capture`

## Requirements
- R1: A retiring load (`ret_kind` = 2'b00) produces one entry that carries its address and the loaded value from `ret_data`.
- R2: Retiring stores (2'b01) and branches (2'b10) go into the same log as loads, and all entries reach memory in retirement order.
- R3: An event with `ret_kind` = 2'b11 produces no entry and does not advance the window count.
- R4: The entry layout is as follows, counting from the LSB:
  - `ret_data` in bits [DW-1:0];
  - `ret_addr` in bits [DW+AW-1:DW];
  - the type tag in bits [DW+AW+1:DW+AW];
  - the window mark in bit DW+AW+2.
- R5: Entries are written to consecutive word addresses starting at `cfg_base`. After an entry is written at `cfg_limit`, the next one goes to `cfg_base`.
- R6: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr` and `mem_wdata` hold their values on the next cycle.
- R7: `ret_stall` is high exactly when DEPTH entries are buffered. An event presented during a stall is not taken, and it is logged once after the stall clears.
- R8: When the next write address lies outside [`cfg_base`, `cfg_limit`], the unit does the following:
  - it issues no write;
  - it discards the head entry;
  - it sets `trace_err`, which then stays high until reset;
  - the next write goes to `cfg_base`.
- R9: The window mark is set on the first entry after reset and then on every `cfg_window`-th entry. A value of 0 acts as 1.
- R10: After reset, `mem_req`, `ret_stall` and `trace_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | A retirement event is presented |
| ret_kind | input | 2 | 00 load, 01 store, 10 branch, 11 not logged |
| ret_addr | input | AW | Instruction or data address of the event |
| ret_data | input | DW | Loaded value, store data or branch target |
| ret_stall | output | 1 | FIFO full; retirement must hold its event |
| cfg_base | input | MW | First word address of the trace region |
| cfg_limit | input | MW | Last word address of the trace region |
| cfg_window | input | CW | Entries per window |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | MW | Write word address |
| mem_wdata | output | AW+DW+3 | Entry being written |
| mem_ack | input | 1 | Write accepted on this edge |
| trace_err | output | 1 | Sticky bounds-violation flag |

## Verification
An event accepted on one edge appears on `mem_req`/`mem_addr`/`mem_wdata` just after that edge. It is written on the next edge when `mem_ack` is high. The bench logs writes at posedges and compares the log only after the drain cycles have passed. `ret_stall` changes only at an edge, so the bench reads it at the negedge before the edge it governs, and it holds an event until that read shows no stall. A violating entry sets `trace_err` on the edge after it reaches the FIFO head, so the flag is checked two cycles after the event is accepted.

// File: rtl/trace_capture.sv
module trace_capture #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int MW    = 16,
  parameter int DEPTH = 4,
  parameter int CW    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_valid,
  input  logic [1:0]        ret_kind,
  input  logic [AW-1:0]     ret_addr,
  input  logic [DW-1:0]     ret_data,
  output logic              ret_stall,
  input  logic [MW-1:0]     cfg_base,
  input  logic [MW-1:0]     cfg_limit,
  input  logic [CW-1:0]     cfg_window,
  output logic              mem_req,
  output logic [MW-1:0]     mem_addr,
  output logic [AW+DW+2:0]  mem_wdata,
  input  logic              mem_ack,
  output logic              trace_err
);
  localparam int EW = AW + DW + 3;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] FULL = (PW+1)'(DEPTH);

  logic [EW-1:0] slot [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW:0]   cnt;
  logic [MW-1:0] wptr;
  logic [CW-1:0] wcnt;
  logic [CW:0]   wnext;

  wire empty     = (cnt == '0);
  wire in_region = (wptr >= cfg_base) && (wptr <= cfg_limit);
  wire accept    = ret_valid && !ret_stall && (ret_kind != 2'b11);
  wire drop      = !empty && !in_region;
  wire written   = mem_req && mem_ack;
  wire pop       = written || drop;
  wire mark      = (wcnt == '0);

  assign ret_stall = (cnt == FULL);
  assign mem_req   = !empty && in_region;
  assign mem_addr  = wptr;
  assign mem_wdata = slot[rd_ptr];
  assign wnext     = {1'b0, wcnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (accept) slot[wr_ptr] <= {mark, ret_kind, ret_addr, ret_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      wptr      <= cfg_base;
      wcnt      <= '0;
      trace_err <= 1'b0;
    end else begin
      if (accept) begin
        wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
        wcnt   <= (wnext >= {1'b0, cfg_window}) ? '0 : wnext[CW-1:0];
      end
      if (pop) rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({accept, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (drop) begin
        wptr      <= cfg_base;
        trace_err <= 1'b1;
      end else if (written) begin
        wptr <= (wptr == cfg_limit) ? cfg_base : wptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk #(
  parameter int MW = 16,
  parameter int EW = 51
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [MW-1:0] mem_addr,
  input logic [EW-1:0] mem_wdata,
  input logic [MW-1:0] cfg_base,
  input logic [MW-1:0] cfg_limit,
  input logic          trace_err
);
  assert_req_in_region_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr >= cfg_base && mem_addr <= cfg_limit));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trace_err |=> trace_err);

  assert_hold_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (!mem_req || !$stable(cfg_base) || !$stable(cfg_limit) ||
      mem_addr == (($past(mem_addr) == cfg_limit) ? cfg_base : $past(mem_addr) + 1'b1)));
endmodule

bind trace_capture trace_capture_chk #(.MW(MW), .EW(AW+DW+3)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cfg_base(cfg_base),
  .cfg_limit(cfg_limit), .trace_err(trace_err)
);

// File: tb/tb_trace_capture.sv
`timescale 1ns/1ps
module tb_trace_capture;
  logic clk = 0, rst_n = 0;
  logic ret_valid = 0;
  logic [1:0] ret_kind = 0;
  logic [15:0] ret_addr = 0;
  logic [31:0] ret_data = 0;
  logic ret_stall;
  logic [15:0] cfg_base = 16'h0100, cfg_limit = 16'h0105, cfg_window = 16'd3;
  logic mem_req, mem_ack = 1, trace_err;
  logic [15:0] mem_addr;
  logic [50:0] mem_wdata;

  int checks = 0, fails = 0, nlog = 0;
  logic [15:0] la [64];
  logic [50:0] ld [64];

  always #2.5 clk = ~clk;

  trace_capture dut (.*);

  always @(posedge clk) begin
    if (!rst_n) nlog <= 0;
    else if (mem_req && mem_ack && nlog < 64) begin
      la[nlog] <= mem_addr; ld[nlog] <= mem_wdata; nlog <= nlog + 1;
    end
  end

  localparam logic [49:0] VEC [8] = '{
    {2'b00, 16'h1000, 32'hDEADBEEF},
    {2'b01, 16'h2004, 32'h00000011},
    {2'b10, 16'h0040, 32'h00000044},
    {2'b11, 16'h3333, 32'h33333333},
    {2'b00, 16'h1008, 32'hCAFEF00D},
    {2'b00, 16'h100C, 32'h00000000},
    {2'b01, 16'h2008, 32'hFFFFFFFF},
    {2'b10, 16'h0080, 32'h12345678}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [49:0] v);
    @(negedge clk);
    ret_valid = 1; {ret_kind, ret_addr, ret_data} = v;
    while (ret_stall) @(negedge clk);
    @(negedge clk);
    ret_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int j;
    logic [50:0] exp;
    repeat (3) @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(mem_req == 0, "R10", "mem_req after reset", 64'(mem_req), 0);
    chk(ret_stall == 0, "R10", "ret_stall after reset", 64'(ret_stall), 0);
    chk(trace_err == 0, "R10", "trace_err after reset", 64'(trace_err), 0);

    for (int i = 0; i < 8; i++) send(VEC[i]);
    repeat (4) @(negedge clk);
    chk(nlog == 7, "R3", "entry count with one 2'b11 event", 64'(nlog), 7);
    j = 0;
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][49:48] != 2'b11) begin
        exp = {(j % 3 == 0), VEC[i]};
        chk(la[j] == 16'h0100 + 16'(j % 6), "R5", "write address", 64'(la[j]), 64'(16'h0100 + 16'(j % 6)));
        chk(ld[j][50] == exp[50], "R9", "window mark", 64'(ld[j][50]), 64'(exp[50]));
        chk(ld[j] == exp, (VEC[i][49:48] == 2'b00) ? "R1" : "R2", "entry (R4 layout)", 64'(ld[j]), 64'(exp));
        j++;
      end
    end

    do_reset();
    mem_ack = 0;
    for (int i = 0; i < 4; i++) send(VEC[i == 3 ? 4 : i]);
    chk(ret_stall == 1, "R7", "stall with four buffered", 64'(ret_stall), 1);
    chk(mem_req == 1 && mem_addr == 16'h0100, "R6", "pending request address", 64'(mem_addr), 64'h0100);
    ret_valid = 1; {ret_kind, ret_addr, ret_data} = VEC[7];
    repeat (3) @(negedge clk);
    chk(ret_stall == 1, "R7", "stall held while no ack", 64'(ret_stall), 1);
    chk(mem_wdata == {1'b1, VEC[0]}, "R6", "pending data held", 64'(mem_wdata), 64'({1'b1, VEC[0]}));
    chk(nlog == 0, "R6", "no write without ack", 64'(nlog), 0);
    mem_ack = 1;
    while (ret_stall) @(negedge clk);
    @(negedge clk); ret_valid = 0;
    repeat (8) @(negedge clk);
    chk(nlog == 5, "R7", "entries after stall", 64'(nlog), 5);
    for (int i = 0; i < 5; i++) begin
      logic [49:0] v;
      v = (i == 3) ? VEC[4] : (i == 4) ? VEC[7] : VEC[i];
      exp = {(i % 3 == 0), v};
      chk(la[i] == 16'h0100 + 16'(i), "R7", "address after stall", 64'(la[i]), 64'(16'h0100 + 16'(i)));
      chk(ld[i] == exp, "R7", "entry order after stall", 64'(ld[i]), 64'(exp));
    end

    cfg_base = 16'h0200; cfg_limit = 16'h0203;
    send(VEC[1]);
    @(negedge clk);
    chk(trace_err == 1, "R8", "error after out-of-region write", 64'(trace_err), 1);
    chk(nlog == 5, "R8", "violating entry not written", 64'(nlog), 5);
    send(VEC[2]);
    repeat (2) @(negedge clk);
    chk(nlog == 6, "R8", "write after violation", 64'(nlog), 6);
    chk(la[5] == 16'h0200, "R8", "address reloads from base", 64'(la[5]), 64'h0200);
    chk(ld[5][49:0] == VEC[2], "R8", "entry after violation", 64'(ld[5][49:0]), 64'(VEC[2]));
    chk(trace_err == 1, "R8", "error stays set", 64'(trace_err), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule